// File: doc/BRIEF.md
# Timer Interrupt Priority Controller

This block holds one byte-wide control register for each of three timer channels and decides which pending timer interrupt, if any, goes to the processor. A channel's register carries a three-bit priority level and a pending flag. A one-cycle pulse from a timer sets the flag. Software can also set or clear the flag through the register bus.

Every cycle, the block looks at all channels whose flag is set. It keeps only those whose level is strictly above the processor's current priority level, and only while the processor's global disable input is low. Among those, it presents the highest level to the processor as a valid signal, a channel index and the level. Ties go to the lowest channel index. When the processor pulses its accept input, the flag of the channel being presented in that cycle is cleared.

The register file sits on a simple bus: one write strobe, one shared address, write data, and combinational read data. The channel registers occupy consecutive byte addresses starting at 0x7A.

Top module: `tic_irq_ctrl`

## Requirements
- R1: After reset, every channel's level and flag are 0, every register reads 0x00, and irq_valid is 0.
- R2: Channel i is at byte address 0x7A+i. Bits 2..0 hold the level and bit 3 holds the flag. A write to any other address has no effect, and reading any other address returns 0x00.
- R3: Bits 7..4 of every register ignore written values and always read as 0.
- R4: A pulse on tmr_evt[i] sets the flag of channel i. The flag reads 1 from the following cycle onward.
- R5: A bus write sets or clears the flag to the value of bit 3. A flag set by software is forwarded exactly like one set by a timer.
- R6: A channel with level 0 is never presented, whatever its flag.
- R7: A pending channel is presented only when its level is strictly greater than cpu_ipl.
- R8: While cpu_idis is 1, irq_valid is 0.
- R9: Among eligible channels, the one with the highest level is presented. Among equal levels, the lowest index wins. irq_chan and irq_level report that channel.
- R10: irq_ack while irq_valid is 1 clears only the flag of the presented channel, from the next cycle on. irq_ack while irq_valid is 0 changes nothing.
- R11: In one cycle, a timer pulse beats a bus write to the same flag, and a bus write beats an accept of the same channel.
- R12: irq_valid, irq_chan and irq_level follow cpu_ipl and cpu_idis in the same cycle, with no register between them.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 8 | Byte address for read and write |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for addr, combinational |
| tmr_evt | input | 3 | One-cycle event pulses, one per timer channel |
| cpu_ipl | input | 3 | Processor's current priority level |
| cpu_idis | input | 1 | Global interrupt disable |
| irq_ack | input | 1 | Processor accepts the presented interrupt |
| irq_valid | output | 1 | An interrupt is being presented |
| irq_chan | output | 2 | Index of the presented channel |
| irq_level | output | 3 | Level of the presented channel |

## Verification
The clear-on-accept property assumes that irq_ack is treated as an accept only in a cycle where irq_valid is high. It also assumes that neither a timer pulse nor a bus write hits the same channel in that cycle. The bench therefore raises accepts only when it has set up a known pending winner, except for the one directed case that tests an accept with no valid request. The tie-break and winner properties assume that the processor level and disable inputs are stable between clock edges. The bench changes them only on falling edges, and it samples the outputs a short delay later.

// File: rtl/tic_pkg.sv
package tic_pkg;
    localparam int LVL_W = 3;

    typedef struct packed {
        logic [LVL_W-1:0] level;
        logic             flag;
    } chan_st_t;
endpackage

// File: rtl/tic_chan_reg.sv
module tic_chan_reg
    import tic_pkg::*;
#(
    parameter int          AW       = 8,
    parameter int          DW       = 8,
    parameter logic [AW-1:0] MY_ADDR = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [AW-1:0]    addr,
    input  logic [DW-1:0]    wdata,
    input  logic             hw_evt,
    input  logic             ack_hit,
    output logic [LVL_W-1:0] level,
    output logic             flag,
    output logic [DW-1:0]    rdata
);
    localparam int PAD_W = DW - LVL_W - 1;

    chan_st_t st_d, st_q;
    logic     hit;

    assign hit = (addr == MY_ADDR);

    always_comb begin
        st_d = st_q;
        if (wr_en && hit) begin
            st_d.level = wdata[LVL_W-1:0];
            st_d.flag  = wdata[LVL_W];
        end else if (ack_hit) begin
            st_d.flag = 1'b0;
        end
        if (hw_evt) begin
            st_d.flag = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign level = st_q.level;
    assign flag  = st_q.flag;
    assign rdata = hit ? {{PAD_W{1'b0}}, st_q.flag, st_q.level} : '0;
endmodule

// File: rtl/tic_arbiter.sv
module tic_arbiter
    import tic_pkg::*;
#(
    parameter int NUM_CH = 3,
    parameter int CH_W   = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
    input  logic [NUM_CH-1:0][LVL_W-1:0] level_vec,
    input  logic [NUM_CH-1:0]            flag_vec,
    input  logic [LVL_W-1:0]             cpu_ipl,
    input  logic                         cpu_idis,
    output logic                         win_valid,
    output logic [CH_W-1:0]              win_chan,
    output logic [LVL_W-1:0]             win_level
);
    logic found;

    always_comb begin
        found     = 1'b0;
        win_chan  = '0;
        win_level = '0;
        for (int i = 0; i < NUM_CH; i++) begin
            if (flag_vec[i] && (level_vec[i] > cpu_ipl) &&
                (!found || (level_vec[i] > win_level))) begin
                found     = 1'b1;
                win_chan  = CH_W'(i);
                win_level = level_vec[i];
            end
        end
        win_valid = found && !cpu_idis;
    end
endmodule

// File: rtl/tic_irq_ctrl.sv
module tic_irq_ctrl
    import tic_pkg::*;
#(
    parameter int            NUM_CH    = 3,
    parameter int            AW        = 8,
    parameter int            DW        = 8,
    parameter logic [AW-1:0] BASE_ADDR = 8'h7A,
    parameter int            CH_W      = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [AW-1:0]     addr,
    input  logic [DW-1:0]     wdata,
    output logic [DW-1:0]     rdata,
    input  logic [NUM_CH-1:0] tmr_evt,
    input  logic [LVL_W-1:0]  cpu_ipl,
    input  logic              cpu_idis,
    input  logic              irq_ack,
    output logic              irq_valid,
    output logic [CH_W-1:0]   irq_chan,
    output logic [LVL_W-1:0]  irq_level
);
    logic [NUM_CH-1:0][LVL_W-1:0] level_vec;
    logic [NUM_CH-1:0]            flag_vec;
    logic [NUM_CH-1:0][DW-1:0]    ch_rdata;
    logic [NUM_CH-1:0]            ack_hit;

    for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
        assign ack_hit[g] = irq_ack && irq_valid && (irq_chan == CH_W'(g));

        tic_chan_reg #(
            .AW      (AW),
            .DW      (DW),
            .MY_ADDR (BASE_ADDR + AW'(g))
        ) u_reg (
            .clk     (clk),
            .rst_n   (rst_n),
            .wr_en   (wr_en),
            .addr    (addr),
            .wdata   (wdata),
            .hw_evt  (tmr_evt[g]),
            .ack_hit (ack_hit[g]),
            .level   (level_vec[g]),
            .flag    (flag_vec[g]),
            .rdata   (ch_rdata[g])
        );
    end

    always_comb begin
        rdata = '0;
        for (int i = 0; i < NUM_CH; i++) begin
            rdata = rdata | ch_rdata[i];
        end
    end

    tic_arbiter #(
        .NUM_CH (NUM_CH),
        .CH_W   (CH_W)
    ) u_arb (
        .level_vec (level_vec),
        .flag_vec  (flag_vec),
        .cpu_ipl   (cpu_ipl),
        .cpu_idis  (cpu_idis),
        .win_valid (irq_valid),
        .win_chan  (irq_chan),
        .win_level (irq_level)
    );
endmodule

// File: rtl/tic_chk.sv
module tic_chk
    import tic_pkg::*;
#(
    parameter int            NUM_CH    = 3,
    parameter int            AW        = 8,
    parameter int            DW        = 8,
    parameter logic [AW-1:0] BASE_ADDR = 8'h7A,
    parameter int            CH_W      = 2
) (
    input logic                         clk,
    input logic                         rst_n,
    input logic                         wr_en,
    input logic [AW-1:0]                addr,
    input logic [DW-1:0]                rdata,
    input logic [NUM_CH-1:0]            tmr_evt,
    input logic [LVL_W-1:0]             cpu_ipl,
    input logic                         cpu_idis,
    input logic                         irq_ack,
    input logic                         irq_valid,
    input logic [CH_W-1:0]              irq_chan,
    input logic [LVL_W-1:0]             irq_level,
    input logic [NUM_CH-1:0][LVL_W-1:0] level_vec,
    input logic [NUM_CH-1:0]            flag_vec
);
    assert_upper_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
        rdata[DW-1:LVL_W+1] == '0);

    assert_nonzero_R6: assert property (@(posedge clk) disable iff (!rst_n)
        irq_valid |-> (irq_level != '0));

    assert_strict_R7: assert property (@(posedge clk) disable iff (!rst_n)
        irq_valid |-> (irq_level > cpu_ipl));

    assert_masked_R8: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_idis |-> !irq_valid);

    for (genvar g = 0; g < NUM_CH; g++) begin : g_chk
        assert_evt_set_R4: assert property (@(posedge clk) disable iff (!rst_n)
            tmr_evt[g] |=> flag_vec[g]);

        assert_winner_R9: assert property (@(posedge clk) disable iff (!rst_n)
            (irq_valid && irq_chan == CH_W'(g)) |->
                (flag_vec[g] && level_vec[g] == irq_level));

        assert_no_better_R9: assert property (@(posedge clk) disable iff (!rst_n)
            (irq_valid && flag_vec[g]) |-> (level_vec[g] <= irq_level));

        assert_ack_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
            (irq_ack && irq_valid && irq_chan == CH_W'(g) && !tmr_evt[g] &&
             !(wr_en && addr == BASE_ADDR + AW'(g))) |=> !flag_vec[g]);
    end
endmodule

bind tic_irq_ctrl tic_chk #(
    .NUM_CH    (NUM_CH),
    .AW        (AW),
    .DW        (DW),
    .BASE_ADDR (BASE_ADDR),
    .CH_W      (CH_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .addr      (addr),
    .rdata     (rdata),
    .tmr_evt   (tmr_evt),
    .cpu_ipl   (cpu_ipl),
    .cpu_idis  (cpu_idis),
    .irq_ack   (irq_ack),
    .irq_valid (irq_valid),
    .irq_chan  (irq_chan),
    .irq_level (irq_level),
    .level_vec (level_vec),
    .flag_vec  (flag_vec)
);

// File: tb/tic_irq_ctrl_tb.sv
module tic_irq_ctrl_tb;
    localparam logic [7:0] BASE = 8'h7A;

    typedef struct packed {
        logic [8:0] lv;   // {ch2, ch1, ch0} levels
        logic [2:0] fl;   // {ch2, ch1, ch0} flags
        logic [2:0] ipl;
        logic       dis;
        logic       ev;   // expected valid
        logic [1:0] ec;   // expected channel
        logic [2:0] el;   // expected level
    } vec_t;

    localparam int NV = 8;
    localparam vec_t VECS [NV] = '{
        '{9'o321, 3'b111, 3'd0, 1'b0, 1'b1, 2'd2, 3'd3},  // R9 highest
        '{9'o321, 3'b111, 3'd2, 1'b0, 1'b1, 2'd2, 3'd3},  // R7
        '{9'o321, 3'b111, 3'd3, 1'b0, 1'b0, 2'd0, 3'd0},  // R7 equal blocks
        '{9'o555, 3'b110, 3'd4, 1'b0, 1'b1, 2'd1, 3'd5},  // R9 tie
        '{9'o555, 3'b111, 3'd4, 1'b1, 1'b0, 2'd0, 3'd0},  // R8
        '{9'o070, 3'b101, 3'd0, 1'b0, 1'b0, 2'd0, 3'd0},  // R6
        '{9'o704, 3'b011, 3'd3, 1'b0, 1'b1, 2'd0, 3'd4},  // R6 R9
        '{9'o777, 3'b111, 3'd6, 1'b0, 1'b1, 2'd0, 3'd7}   // R9 tie all
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [7:0] addr = 8'h00;
    logic [7:0] wdata = 8'h00;
    logic [7:0] rdata;
    logic [2:0] tmr_evt = 3'b000;
    logic [2:0] cpu_ipl = 3'd0;
    logic       cpu_idis = 1'b0;
    logic       irq_ack = 1'b0;
    logic       irq_valid;
    logic [1:0] irq_chan;
    logic [2:0] irq_level;

    int n_chk = 0;
    int n_bad = 0;

    always #10 clk = ~clk;

    tic_irq_ctrl u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .addr      (addr),
        .wdata     (wdata),
        .rdata     (rdata),
        .tmr_evt   (tmr_evt),
        .cpu_ipl   (cpu_ipl),
        .cpu_idis  (cpu_idis),
        .irq_ack   (irq_ack),
        .irq_valid (irq_valid),
        .irq_chan  (irq_chan),
        .irq_level (irq_level)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    endtask

    // Called at a falling edge; returns at the next falling edge.
    task automatic bus_write(input logic [7:0] a, input logic [7:0] d);
        wr_en = 1'b1;
        addr  = a;
        wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic read_chk(input string req, input logic [7:0] a, input logic [7:0] exp);
        addr = a;
        #1;
        check(req, {24'd0, rdata}, {24'd0, exp});
    endtask

    task automatic out_chk(input string req, input logic v, input logic [1:0] c,
                           input logic [2:0] l);
        #1;
        check(req, {31'd0, irq_valid}, {31'd0, v});
        if (v) begin
            check(req, {30'd0, irq_chan}, {30'd0, c});
            check(req, {29'd0, irq_level}, {29'd0, l});
        end
    endtask

    task automatic pulse_ack();
        irq_ack = 1'b1;
        @(negedge clk);
        irq_ack = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        for (int c = 0; c < 3; c++) read_chk("R1", BASE + 8'(c), 8'h00);
        out_chk("R1", 1'b0, 2'd0, 3'd0);

        // Vector table: R6 R7 R8 R9
        for (int v = 0; v < NV; v++) begin
            for (int c = 0; c < 3; c++) begin
                bus_write(BASE + 8'(c), {4'h0, VECS[v].fl[c], VECS[v].lv[3*c +: 3]});
            end
            cpu_ipl  = VECS[v].ipl;
            cpu_idis = VECS[v].dis;
            out_chk("R9 vector", VECS[v].ev, VECS[v].ec, VECS[v].el);
        end
        cpu_ipl  = 3'd0;
        cpu_idis = 1'b0;
        for (int c = 0; c < 3; c++) bus_write(BASE + 8'(c), 8'h00);
        out_chk("R1", 1'b0, 2'd0, 3'd0);

        // R3 upper bits ignored
        bus_write(BASE, 8'hF5);
        read_chk("R3", BASE, 8'h05);

        // R2 unmapped addresses
        bus_write(8'h7D, 8'h0F);
        bus_write(8'h79, 8'h0F);
        read_chk("R2", 8'h7D, 8'h00);
        read_chk("R2", 8'h79, 8'h00);
        read_chk("R2", BASE + 8'd1, 8'h00);
        read_chk("R2", BASE + 8'd2, 8'h00);
        read_chk("R2", BASE, 8'h05);
        out_chk("R2", 1'b0, 2'd0, 3'd0);

        // R4 timer pulse sets flag
        bus_write(BASE + 8'd1, 8'h02);
        out_chk("R4", 1'b0, 2'd0, 3'd0);
        tmr_evt = 3'b010;
        @(negedge clk);
        tmr_evt = 3'b000;
        read_chk("R4", BASE + 8'd1, 8'h0A);
        out_chk("R4", 1'b1, 2'd1, 3'd2);

        // R12 same-cycle response to ipl / idis
        cpu_ipl = 3'd2;
        out_chk("R12", 1'b0, 2'd0, 3'd0);
        cpu_ipl = 3'd1;
        out_chk("R12", 1'b1, 2'd1, 3'd2);
        cpu_idis = 1'b1;
        out_chk("R8", 1'b0, 2'd0, 3'd0);
        cpu_idis = 1'b0;

        // R10 accept clears only the presented channel
        bus_write(BASE + 8'd2, 8'h0D);
        out_chk("R10", 1'b1, 2'd2, 3'd5);
        pulse_ack();
        read_chk("R10", BASE + 8'd2, 8'h05);
        read_chk("R10", BASE + 8'd1, 8'h0A);
        out_chk("R10", 1'b1, 2'd1, 3'd2);

        // R10 accept without valid ignored
        cpu_ipl = 3'd7;
        pulse_ack();
        read_chk("R10", BASE + 8'd1, 8'h0A);
        cpu_ipl = 3'd1;

        // R11 timer pulse beats software clear
        wr_en   = 1'b1;
        addr    = BASE + 8'd1;
        wdata   = 8'h02;
        tmr_evt = 3'b010;
        @(negedge clk);
        wr_en   = 1'b0;
        tmr_evt = 3'b000;
        read_chk("R11", BASE + 8'd1, 8'h0A);

        // R11 software write beats accept
        out_chk("R11", 1'b1, 2'd1, 3'd2);
        wr_en   = 1'b1;
        addr    = BASE + 8'd1;
        wdata   = 8'h0A;
        irq_ack = 1'b1;
        @(negedge clk);
        wr_en   = 1'b0;
        irq_ack = 1'b0;
        read_chk("R11", BASE + 8'd1, 8'h0A);
        pulse_ack();
        read_chk("R10", BASE + 8'd1, 8'h02);
        out_chk("R10", 1'b0, 2'd0, 3'd0);

        // R5 software set and clear
        bus_write(BASE + 8'd2, 8'h0D);
        out_chk("R5", 1'b1, 2'd2, 3'd5);
        bus_write(BASE + 8'd2, 8'h05);
        read_chk("R5", BASE + 8'd2, 8'h05);
        out_chk("R5", 1'b0, 2'd0, 3'd0);

        finish_run();
    end
endmodule